// File: doc/BRIEF.md
# Two-Digit Decimal Adder with Seven-Segment Readout

This block adds two packed decimal operands of two digits each, plus a one-bit carry-in. It returns a three-digit decimal sum whose top digit can only be 0 or 1. Each digit position forms a binary sum of its two digits and the incoming carry. When that sum is above nine, the position subtracts ten and passes a decimal carry to the next position. The carry therefore ripples from the units digit to the tens digit, and the last carry becomes the hundreds digit.

The block also checks every operand nibble. When any nibble holds a code above nine, it raises an error flag. The block drives active-low seven-segment patterns for each operand digit and for each sum digit. Every result is captured in an output register, so all outputs change together one clock after the inputs are applied. The digit count is a parameter and defaults to two.

Top module: `bcd2_adder_disp`

## Requirements
- R1: All outputs are registered. Inputs present at a rising edge of `clk` appear on the outputs after that edge. While `rst_n` is low, `sum_o` is 0, `err_o` is 0 and every segment field is 7'h7F (all segments off).
- R2: Units digit: t0 = a_i[3:0] + b_i[3:0] + cin_i is computed at 5 bits. If t0 > 9, then sum_o[3:0] = (t0 - 10) mod 16 and a carry of 1 passes to the tens digit. Otherwise sum_o[3:0] = t0 and the carry is 0.
- R3: Tens digit: t1 = a_i[7:4] + b_i[7:4] + carry from the units digit. It is corrected by the same rule into sum_o[7:4], and that rule produces the tens carry.
- R4: The hundreds field sum_o[11:8] equals the tens carry, so it is always 0 or 1.
- R5: For valid operands, sum_o read as three decimal digits equals (10*A1+A0) + (10*B1+B0) + cin_i. Every sum digit is 0 to 9.
- R6: `err_o` is 1 exactly when at least one of the four operand nibbles is greater than 9.
- R7: Segment fields are 7 bits wide, ordered {g,f,e,d,c,b,a} (bit 6 = g, bit 0 = a), and active-low. Digits 0 to 9 light the conventional segments, for example 0 = 7'h40, 1 = 7'h79 and 8 = 7'h00. Codes 10 to 15 give 7'h7F.
- R8: seg_a_o[6:0] shows the units digit of `a_i` and seg_a_o[13:7] shows its tens digit. `seg_b_o` shows `b_i` the same way.
- R9: seg_s_o[6:0], [13:7] and [20:14] show the units, tens and hundreds sum digits.
- R10: When operand nibbles are invalid, the sum still follows the per-digit rules of R2 to R4 applied to the raw nibble values. The segment fields still follow R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_i | input | 8 | Operand A, packed decimal, tens digit in [7:4] |
| b_i | input | 8 | Operand B, packed decimal, tens digit in [7:4] |
| cin_i | input | 1 | Decimal carry into the units digit |
| sum_o | output | 12 | Sum digits: hundreds, tens, units |
| err_o | output | 1 | High when any operand nibble exceeds 9 |
| seg_a_o | output | 14 | Active-low segments for the two digits of A |
| seg_b_o | output | 14 | Active-low segments for the two digits of B |
| seg_s_o | output | 21 | Active-low segments for the three sum digits |

## Verification
The bench sweeps every valid digit combination with both carry-in values. This covers sums that need no correction, a correction in the units digit only, a correction in the tens digit only, and correction in both with a ripple into the hundreds digit. Directed extremes check the zero sum, the 99+99+1 maximum and the 09+01 and 90+10 carry boundaries. These separate an off-by-one compare threshold from a dropped or misrouted carry. A second sweep sets each nibble position to every code from 10 to 15. It shows that the error flag tracks each position on its own and that the wrapped 5-bit arithmetic and blank segment patterns still follow their rules.

// File: rtl/bcd_adder_pkg.sv
package bcd_adder_pkg;
    localparam int unsigned DIG_W = 4;
    localparam int unsigned SEG_W = 7;
    localparam logic [6:0]  SEG_BLANK = 7'h7F;

    typedef logic [DIG_W-1:0] digit_t;
    typedef logic [SEG_W-1:0] seg_t;
endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
    import bcd_adder_pkg::*;
(
    input  digit_t x_i,
    input  digit_t y_i,
    input  logic   c_i,
    output digit_t s_o,
    output logic   c_o
);
    localparam int unsigned TW = DIG_W + 1;

    logic [TW-1:0] raw;
    logic [TW-1:0] fixed;
    logic          over;

    always_comb begin
        raw   = {1'b0, x_i} + {1'b0, y_i} + {{DIG_W{1'b0}}, c_i};
        over  = raw > TW'(9);
        fixed = over ? raw - TW'(10) : raw;
        s_o   = fixed[DIG_W-1:0];
        c_o   = over;
    end
endmodule

// File: rtl/seg7_enc.sv
module seg7_enc
    import bcd_adder_pkg::*;
(
    input  digit_t dig_i,
    output seg_t   seg_o
);
    // active-low, bit order {g,f,e,d,c,b,a}
    always_comb begin
        case (dig_i)
            4'd0:    seg_o = ~7'h3F;
            4'd1:    seg_o = ~7'h06;
            4'd2:    seg_o = ~7'h5B;
            4'd3:    seg_o = ~7'h4F;
            4'd4:    seg_o = ~7'h66;
            4'd5:    seg_o = ~7'h6D;
            4'd6:    seg_o = ~7'h7D;
            4'd7:    seg_o = ~7'h07;
            4'd8:    seg_o = ~7'h7F;
            4'd9:    seg_o = ~7'h6F;
            default: seg_o = SEG_BLANK;
        endcase
    end
endmodule

// File: rtl/bcd2_adder_disp.sv
module bcd2_adder_disp
    import bcd_adder_pkg::*;
#(
    parameter int unsigned NDIG = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NDIG*DIG_W-1:0]        a_i,
    input  logic [NDIG*DIG_W-1:0]        b_i,
    input  logic                         cin_i,
    output logic [(NDIG+1)*DIG_W-1:0]    sum_o,
    output logic                         err_o,
    output logic [NDIG*SEG_W-1:0]        seg_a_o,
    output logic [NDIG*SEG_W-1:0]        seg_b_o,
    output logic [(NDIG+1)*SEG_W-1:0]    seg_s_o
);
    localparam int unsigned OPW   = NDIG * DIG_W;
    localparam int unsigned SUMW  = (NDIG + 1) * DIG_W;
    localparam int unsigned SOPW  = NDIG * SEG_W;
    localparam int unsigned SSUMW = (NDIG + 1) * SEG_W;

    typedef struct packed {
        logic [SUMW-1:0]  sum;
        logic             err;
        logic [SOPW-1:0]  seg_a;
        logic [SOPW-1:0]  seg_b;
        logic [SSUMW-1:0] seg_s;
    } out_t;

    logic [NDIG:0]    carry;
    logic [SUMW-1:0]  sum_w;
    logic [SOPW-1:0]  seg_a_w;
    logic [SOPW-1:0]  seg_b_w;
    logic [SSUMW-1:0] seg_s_w;

    out_t out_d;
    out_t out_q;

    assign carry[0] = cin_i;

    // rippled per-digit compare-and-correct chain
    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        bcd_digit_add u_add (
            .x_i (a_i[g*DIG_W +: DIG_W]),
            .y_i (b_i[g*DIG_W +: DIG_W]),
            .c_i (carry[g]),
            .s_o (sum_w[g*DIG_W +: DIG_W]),
            .c_o (carry[g+1])
        );
        seg7_enc u_seg_a (
            .dig_i (a_i[g*DIG_W +: DIG_W]),
            .seg_o (seg_a_w[g*SEG_W +: SEG_W])
        );
        seg7_enc u_seg_b (
            .dig_i (b_i[g*DIG_W +: DIG_W]),
            .seg_o (seg_b_w[g*SEG_W +: SEG_W])
        );
    end

    // top digit is the final carry only
    assign sum_w[SUMW-1 -: DIG_W] = {{(DIG_W-1){1'b0}}, carry[NDIG]};

    for (genvar g = 0; g <= NDIG; g++) begin : g_sum_seg
        seg7_enc u_seg_s (
            .dig_i (sum_w[g*DIG_W +: DIG_W]),
            .seg_o (seg_s_w[g*SEG_W +: SEG_W])
        );
    end

    always_comb begin
        out_d       = out_q;
        out_d.sum   = sum_w;
        out_d.seg_a = seg_a_w;
        out_d.seg_b = seg_b_w;
        out_d.seg_s = seg_s_w;
        out_d.err   = 1'b0;
        for (int i = 0; i < int'(NDIG); i++) begin
            if (a_i[i*DIG_W +: DIG_W] > digit_t'(9)) out_d.err = 1'b1;
            if (b_i[i*DIG_W +: DIG_W] > digit_t'(9)) out_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.sum   <= '0;
            out_q.err   <= 1'b0;
            out_q.seg_a <= {NDIG{SEG_BLANK}};
            out_q.seg_b <= {NDIG{SEG_BLANK}};
            out_q.seg_s <= {(NDIG+1){SEG_BLANK}};
        end else begin
            out_q <= out_d;
        end
    end

    assign sum_o   = out_q.sum;
    assign err_o   = out_q.err;
    assign seg_a_o = out_q.seg_a;
    assign seg_b_o = out_q.seg_b;
    assign seg_s_o = out_q.seg_s;

    logic unused_w;
    assign unused_w = ^{OPW[0]};
endmodule

// File: rtl/bcd2_adder_chk.sv
module bcd2_adder_chk
    import bcd_adder_pkg::*;
#(
    parameter int unsigned NDIG = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NDIG*DIG_W-1:0]        a_i,
    input logic [NDIG*DIG_W-1:0]        b_i,
    input logic                         cin_i,
    input logic [(NDIG+1)*DIG_W-1:0]    sum_o,
    input logic                         err_o,
    input logic [(NDIG+1)*SEG_W-1:0]    seg_s_o
);
    localparam int unsigned SUMW = (NDIG + 1) * DIG_W;

    logic       armed_q;
    logic       in_bad;
    logic       digits_ok;
    logic [4:0] t0_wide;
    logic [3:0] t0_mod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    always_comb begin
        in_bad    = 1'b0;
        digits_ok = 1'b1;
        for (int i = 0; i < int'(NDIG); i++) begin
            if (a_i[i*DIG_W +: DIG_W] > 4'd9) in_bad = 1'b1;
            if (b_i[i*DIG_W +: DIG_W] > 4'd9) in_bad = 1'b1;
        end
        for (int i = 0; i <= int'(NDIG); i++) begin
            if (sum_o[i*DIG_W +: DIG_W] > 4'd9) digits_ok = 1'b0;
        end
        t0_wide = {1'b0, a_i[3:0]} + {1'b0, b_i[3:0]} + {4'd0, cin_i};
        t0_mod  = 4'(t0_wide % 5'd10);
    end

    assert_err_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (err_o == $past(in_bad)));

    assert_digits_decimal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !err_o) |-> digits_ok);

    assert_units_digit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !err_o) |-> (sum_o[3:0] == $past(t0_mod)));

    assert_hundreds_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sum_o[SUMW-1 -: DIG_W] <= 4'd1);

    assert_units_lit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && sum_o[3:0] <= 4'd9) |-> (seg_s_o[6:0] != SEG_BLANK));
endmodule

bind bcd2_adder_disp bcd2_adder_chk #(.NDIG(NDIG)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_i     (a_i),
    .b_i     (b_i),
    .cin_i   (cin_i),
    .sum_o   (sum_o),
    .err_o   (err_o),
    .seg_s_o (seg_s_o)
);

// File: tb/test_bcd2_adder_disp.sv
module test_bcd2_adder_disp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  a_i = 8'h00;
    logic [7:0]  b_i = 8'h00;
    logic        cin_i = 1'b0;
    logic [11:0] sum_o;
    logic        err_o;
    logic [13:0] seg_a_o;
    logic [13:0] seg_b_o;
    logic [20:0] seg_s_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [11:0] sum;
        logic        err;
        logic [13:0] sa;
        logic [13:0] sb;
        logic [20:0] ss;
        int          dec;
        string       tag;
    } exp_t;

    exp_t q[$];

    bcd2_adder_disp #(.NDIG(2)) i_bcd2_adder_disp (
        .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
        .sum_o(sum_o), .err_o(err_o), .seg_a_o(seg_a_o), .seg_b_o(seg_b_o),
        .seg_s_o(seg_s_o)
    );

    always #10 clk = ~clk;

    // R7: active-low {g,f,e,d,c,b,a}
    function automatic logic [6:0] seg_of(input logic [3:0] d);
        case (d)
            4'd0: return 7'h40;
            4'd1: return 7'h79;
            4'd2: return 7'h24;
            4'd3: return 7'h30;
            4'd4: return 7'h19;
            4'd5: return 7'h12;
            4'd6: return 7'h02;
            4'd7: return 7'h78;
            4'd8: return 7'h00;
            4'd9: return 7'h10;
            default: return 7'h7F;
        endcase
    endfunction

    function automatic exp_t model(input logic [7:0] a, input logic [7:0] b,
                                   input logic c, input string tag);
        exp_t e;
        int t0, t1, s0, s1, c1, c2;
        t0 = int'(a[3:0]) + int'(b[3:0]) + int'(c);
        if (t0 > 9) begin s0 = (t0 - 10) % 16; c1 = 1; end
        else        begin s0 = t0;             c1 = 0; end
        t1 = int'(a[7:4]) + int'(b[7:4]) + c1;
        if (t1 > 9) begin s1 = (t1 - 10) % 16; c2 = 1; end
        else        begin s1 = t1;             c2 = 0; end
        e.sum = {4'(c2), 4'(s1), 4'(s0)};
        e.err = (a[3:0] > 9) || (a[7:4] > 9) || (b[3:0] > 9) || (b[7:4] > 9);
        e.sa  = {seg_of(a[7:4]), seg_of(a[3:0])};
        e.sb  = {seg_of(b[7:4]), seg_of(b[3:0])};
        e.ss  = {seg_of(4'(c2)), seg_of(4'(s1)), seg_of(4'(s0))};
        e.dec = 10 * int'(a[7:4]) + int'(a[3:0]) + 10 * int'(b[7:4]) + int'(b[3:0]) + int'(c);
        e.tag = tag;
        return e;
    endfunction

    task automatic drive(input logic [7:0] a, input logic [7:0] b,
                         input logic c, input string tag);
        @(negedge clk);
        a_i   = a;
        b_i   = b;
        cin_i = c;
        q.push_back(model(a, b, c, tag));
    endtask

    task automatic check_val(input string req, input logic [31:0] act,
                             input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: results appear after the edge that captured the inputs
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                int got;
                e = q.pop_front();
                check_val({e.tag, " sum"}, 32'(sum_o), 32'(e.sum));
                check_val("R6 err", 32'(err_o), 32'(e.err));
                check_val("R7 R8 seg_a", 32'(seg_a_o), 32'(e.sa));
                check_val("R7 R8 seg_b", 32'(seg_b_o), 32'(e.sb));
                check_val("R9 seg_s", 32'(seg_s_o), 32'(e.ss));
                if (!e.err) begin
                    got = 100 * int'(sum_o[11:8]) + 10 * int'(sum_o[7:4]) + int'(sum_o[3:0]);
                    check_val("R5 decimal", 32'(got), 32'(e.dec));
                end
            end
        end
    end

    initial begin
        #(20 * 60000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check_val("R1 reset sum", 32'(sum_o), 32'h0);
        check_val("R1 reset err", 32'(err_o), 32'h0);
        check_val("R1 reset seg_a", 32'(seg_a_o), 32'h3FFF);
        check_val("R1 reset seg_b", 32'(seg_b_o), 32'h3FFF);
        check_val("R1 reset seg_s", 32'(seg_s_o), 32'h1FFFFF);
        rst_n = 1'b1;

        // directed boundaries
        drive(8'h00, 8'h00, 1'b0, "R1 R2 zero");
        drive(8'h99, 8'h99, 1'b1, "R4 max");
        drive(8'h09, 8'h01, 1'b0, "R2 R3 units carry");
        drive(8'h90, 8'h10, 1'b0, "R3 R4 tens carry");
        drive(8'h45, 8'h54, 1'b1, "R3 ripple");
        drive(8'h05, 8'h04, 1'b0, "R2 no carry");

        // exhaustive valid sweep
        for (int a1 = 0; a1 < 10; a1++)
            for (int a0 = 0; a0 < 10; a0++)
                for (int b1 = 0; b1 < 10; b1++)
                    for (int b0 = 0; b0 < 10; b0++)
                        for (int c = 0; c < 2; c++)
                            drive({4'(a1), 4'(a0)}, {4'(b1), 4'(b0)}, 1'(c), "R5 sweep");

        // invalid nibble in each position: R6 flag, R10 arithmetic
        for (int p = 0; p < 4; p++)
            for (int v = 10; v < 16; v++)
                for (int c = 0; c < 2; c++) begin
                    logic [15:0] ops;
                    ops = 16'h4532;
                    ops[p*4 +: 4] = 4'(v);
                    drive(ops[15:8], ops[7:0], 1'(c), "R10 invalid");
                end
        drive(8'hFF, 8'hFF, 1'b1, "R10 all invalid");

        wait (q.size() == 0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule